// File: doc/BRIEF.md
# LCD Frame Clock Generator

This block turns the display controller's timing clock into a frame-rate strobe. It also decides what happens on the shared clock pin. The clock at `clk` is whichever source the chip has selected: the internal oscillator or the clock arriving on the pin. A range bit selects the divider. With the range bit low, the block divides by a fixed 48, which suits a clock of about 9.6 kHz. With the range bit high, it divides by 48 times a prescaler `q`, which suits a clock of about 230 kHz. Here `q` comes from a 4-bit code, so the frame rate can be set between roughly 60 Hz and 300 Hz.

The divider is a down-counter. It reloads at each frame boundary and takes the range bit and the prescaler code only at that moment, so a frame that is already running keeps its length. Power-down holds the counter cleared and stops the strobes. The pin logic is combinational. From reset, power-down, the oscillator select and the clock-output enable it produces an output value and an output enable for the pad.

Top module: `lcd_frame_clkgen`

## Requirements
- R1: While `rst_n` is low, `pin_oe` is 0 and `frame_stb` is 0.
- R2: With `range_hi` = 0, consecutive `frame_stb` pulses are exactly 48 cycles apart.
- R3: With `range_hi` = 1, consecutive pulses are 48·q cycles apart, where q = 16 + 4·`q_code`. Code 0 gives q = 16, code 2 gives the nominal q = 24 (1152 cycles), and code 15 gives q = 76 (3648 cycles).
- R4: After reset is released, and after `pwr_down` falls, the first pulse is seen P+1 cycles after the first active clock edge. P is the period selected by the inputs on that edge.
- R5: `range_hi` and `q_code` are sampled only on the edge that starts a frame, which is also the edge on which the strobe rises. A change in the middle of a frame does not alter that frame's length. It takes effect from the next frame.
- R6: `frame_stb` is never high for two consecutive cycles.
- R7: While `pwr_down` = 1, no `frame_stb` pulse occurs, and the frame counter is held cleared.
- R8: In power-down, `pin_oe` equals `clk_out_en`, and `pin_o` is 1 whenever `pin_oe` is 1.
- R9: Powered up with the internal oscillator (`osc_ext` = 0), `pin_oe` equals `clk_out_en` and `pin_o` follows `osc_lvl`.
- R10: Powered up with the external oscillator (`osc_ext` = 1), `pin_oe` is 0 whatever `clk_out_en` is. `pin_o` is 0 whenever `pin_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Selected frame-timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | 1 = power-down |
| osc_ext | input | 1 | 1 = external clock on the pin, 0 = internal oscillator |
| clk_out_en | input | 1 | Enables the clock output on the pin |
| range_hi | input | 1 | 0 = divide by 48, 1 = divide by 48·q |
| q_code | input | 4 | Prescaler code, q = 16 + 4·code |
| osc_lvl | input | 1 | Internal oscillator level, mirrored to the pin |
| frame_stb | output | 1 | One-cycle frame strobe |
| pin_o | output | 1 | Pin output value |
| pin_oe | output | 1 | Pin output enable |

## Verification
The bench measures strobe spacing at both ends of the prescaler code range and at the nominal code. A wrong multiplier or an off-by-one reload shows up there as a miscounted gap. It changes the code in the middle of a frame. A design that samples the code continuously would then shorten the running frame instead of the following one. It also counts the startup latency after reset and after power-down exit, and it checks that power-down suppresses strobes. Finally it walks every pin-mode combination. A design that lets the clock-output enable override the external-oscillator mode would drive the pin against the incoming clock.

// File: rtl/lcd_frame_clkgen.sv
module lcd_frame_clkgen #(
  parameter int BASE_DIV = 48,
  parameter int QW       = 4,
  parameter int Q_BASE   = 16,
  parameter int Q_STEP   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_down,
  input  logic          osc_ext,
  input  logic          clk_out_en,
  input  logic          range_hi,
  input  logic [QW-1:0] q_code,
  input  logic          osc_lvl,
  output logic          frame_stb,
  output logic          pin_o,
  output logic          pin_oe
);
  localparam int Q_MAX = Q_BASE + Q_STEP * (2**QW - 1);
  localparam int CNT_W = $clog2(BASE_DIV * Q_MAX + 1);

  logic [CNT_W-1:0] cnt, q_val, period;
  logic             armed;

  // prescaler decode and frame length chosen by live inputs
  assign q_val  = CNT_W'(Q_BASE) + CNT_W'(Q_STEP) * CNT_W'(q_code);
  assign period = range_hi ? CNT_W'(BASE_DIV) * q_val : CNT_W'(BASE_DIV);

  // down-counter: reload marks a frame boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      armed     <= 1'b0;
      frame_stb <= 1'b0;
    end else if (pwr_down) begin
      cnt       <= '0;
      armed     <= 1'b0;
      frame_stb <= 1'b0;
    end else if (cnt == '0) begin
      cnt       <= period - CNT_W'(1);
      armed     <= 1'b1;
      frame_stb <= armed;
    end else begin
      cnt       <= cnt - CNT_W'(1);
      frame_stb <= 1'b0;
    end
  end

  // shared clock pin
  always_comb begin
    pin_oe = 1'b0;
    pin_o  = 1'b0;
    if (rst_n) begin
      if (pwr_down) begin
        pin_oe = clk_out_en;
        pin_o  = clk_out_en;
      end else if (!osc_ext) begin
        pin_oe = clk_out_en;
        pin_o  = clk_out_en & osc_lvl;
      end
    end
  end
endmodule

module lcd_frame_clkgen_chk #(
  parameter int BASE_DIV = 48
) (
  input logic clk,
  input logic rst_n,
  input logic pwr_down,
  input logic osc_ext,
  input logic clk_out_en,
  input logic frame_stb,
  input logic pin_o,
  input logic pin_oe
);
  logic [15:0] gap;
  logic        seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (pwr_down) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (frame_stb) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap != 16'hFFFF) begin
      gap  <= gap + 16'd1;
    end
  end

  always_comb begin
    if (rst_n === 1'b0) AST_RESET_PIN_OFF: assert (!pin_oe); // R1
    if (rst_n === 1'b1 && pwr_down === 1'b0 && osc_ext === 1'b1)
      AST_EXT_NO_DRIVE: assert (!pin_oe); // R10
    if (rst_n === 1'b1 && pwr_down === 1'b1)
      AST_PD_PIN_HIGH: assert (pin_oe == clk_out_en && (!pin_oe || pin_o)); // R8
  end

  AST_PD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !frame_stb); // R7
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |=> !frame_stb); // R6
  AST_MIN_FRAME_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && seen) |-> (gap >= 16'(BASE_DIV - 1))); // R2
endmodule

bind lcd_frame_clkgen lcd_frame_clkgen_chk #(.BASE_DIV(BASE_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .osc_ext(osc_ext),
  .clk_out_en(clk_out_en), .frame_stb(frame_stb), .pin_o(pin_o), .pin_oe(pin_oe)
);

// File: tb/lcd_frame_clkgen_bench.sv
module lcd_frame_clkgen_bench;
  logic clk = 1'b0, rst_n = 1'b0, pwr_down = 1'b0, osc_ext = 1'b0;
  logic clk_out_en = 1'b0, range_hi = 1'b0, osc_lvl = 1'b0;
  logic [3:0] q_code = 4'd2;
  logic frame_stb, pin_o, pin_oe;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lcd_frame_clkgen u_lcd_frame_clkgen (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .osc_ext(osc_ext),
    .clk_out_en(clk_out_en), .range_hi(range_hi), .q_code(q_code),
    .osc_lvl(osc_lvl), .frame_stb(frame_stb), .pin_o(pin_o), .pin_oe(pin_oe)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic next_stb(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!frame_stb && n < 5000);
  endtask

  function automatic int per(bit rh, int code);
    return rh ? 48 * (16 + 4 * code) : 48;
  endfunction

  task automatic t_reset();
    int n;
    rst_n = 1'b0; clk_out_en = 1'b1; osc_ext = 1'b0; range_hi = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 oe", int'(pin_oe), 0);
    check("R1 stb", int'(frame_stb), 0);
    rst_n = 1'b1;
    next_stb(n);
    check("R4 first strobe after reset", n, per(0, 0) + 1);
  endtask

  task automatic t_div48();
    int n;
    range_hi = 1'b0;
    next_stb(n); next_stb(n);
    check("R2 gap", n, 48);
    @(negedge clk);
    check("R6 width", int'(frame_stb), 0);
  endtask

  task automatic t_divq(int code);
    int n;
    range_hi = 1'b1; q_code = 4'(code);
    next_stb(n); next_stb(n);
    check("R3 gap", n, per(1, code));
  endtask

  task automatic t_midframe();
    int n;
    range_hi = 1'b1; q_code = 4'd2;
    next_stb(n); next_stb(n);
    repeat (100) @(negedge clk);
    q_code = 4'd0;
    next_stb(n);
    check("R5 running frame kept", n + 100, per(1, 2));
    next_stb(n);
    check("R5 new code next frame", n, per(1, 0));
    range_hi = 1'b0;
    next_stb(n);
    check("R5 range sampled at boundary", n, per(1, 0));
    next_stb(n);
    check("R5 range applied", n, 48);
  endtask

  task automatic t_pwrdown();
    int n, hits;
    range_hi = 1'b0;
    next_stb(n);
    repeat (10) @(negedge clk);
    pwr_down = 1'b1;
    hits = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (frame_stb) hits++;
    end
    check("R7 no strobes", hits, 0);
    pwr_down = 1'b0; range_hi = 1'b1; q_code = 4'd0;
    next_stb(n);
    check("R7 R4 restart from cleared", n, per(1, 0) + 1);
  endtask

  task automatic t_pins();
    for (int m = 0; m < 8; m++) begin
      bit pd = m[0], ext = m[1], en = m[2];
      for (int l = 0; l < 2; l++) begin
        @(negedge clk);
        pwr_down = pd; osc_ext = ext; clk_out_en = en; osc_lvl = l[0];
        #1;
        if (pd) begin
          check("R8 oe", int'(pin_oe), int'(en));
          check("R8 level", int'(pin_o), int'(en));
        end else if (!ext) begin
          check("R9 oe", int'(pin_oe), int'(en));
          check("R9 level", int'(pin_o), int'(en & l[0]));
        end else begin
          check("R10 oe", int'(pin_oe), 0);
          check("R10 level", int'(pin_o), 0);
        end
      end
    end
    pwr_down = 1'b0; osc_ext = 1'b0;
  endtask

  initial begin
    t_reset();
    t_div48();
    t_divq(2);
    t_divq(0);
    t_divq(15);
    t_midframe();
    t_pwrdown();
    t_pins();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule